// File: doc/BRIEF.md
# Layered Status LED Animator

This block drives one monochrome status LED through a pulse-width output, so that a single pin can show several layers of system state at once. A base pattern gives the overall condition. When the system is not yet usable, the LED shows a double heartbeat: two full-brightness flashes followed by a long pause. When the system is usable, it shows a slow, dim breathing ramp. On top of either base pattern, short full-brightness accents mark pulse-per-second events and traffic on the radio or Ethernet paths.

The system is usable when three conditions hold. Time must be valid. If the PCIe transport is enabled, its link must be up and its DMA/PPS synchronisation established. If the Ethernet transport is enabled, its link must be up. A transport whose enable strap is low plays no part in the decision.

All strobes are single-cycle pulses already in this block's clock domain. Every timing value is derived from a clock-frequency parameter, together with millisecond parameters for each interval.

Top module: `led_status_layer`

## Requirements
- R1: While `time_valid_i` is low, the base pattern is the double heartbeat, whatever the transport inputs are.
- R2: With `pcie_en_i` high, the system counts as ready only if both `pcie_link_i` and `pcie_sync_i` are high. Otherwise the heartbeat is shown.
- R3: With `eth_en_i` high, the system counts as ready exactly when `eth_link_i` is high.
- R4: When ready, the base pattern is a triangular ramp. It steps by one level from 0 up to `BREATH_PEAK` and back down, and one full cycle lasts about `BREATH_MS`. The brightness never exceeds `BREATH_PEAK`.
- R5: The heartbeat brightness is `HB_LEVEL` in two intervals of `HB_FLASH_MS` each. The first interval starts at the beginning of the period and the second starts `HB_GAP_MS` later. Outside these intervals the brightness is zero. The period is `HB_PERIOD_MS`.
- R6: A pulse on any strobe input (`pps_stb_i`, any bit of `rf_stb_i`, `eth_rx_stb_i`, `eth_tx_stb_i`) raises the brightness to at least `ACCENT_LEVEL` for `ACCENT_MS`. The final brightness is the larger of the base level and the accent level.
- R7: While `pcie_en_i` is low, `pcie_link_i` and `pcie_sync_i` have no effect on the displayed pattern.
- R8: A strobe that arrives while an accent is active restarts the full accent duration. Strobes do not queue.
- R9: The LED is driven from a free-running 8-bit counter. It is on in a cycle when the counter is below the brightness, so that brightness B gives B lit cycles in every 256.
- R10: While `rst_n` is low, the LED is off. After release, the heartbeat phase starts from its beginning, so the first flash begins immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_valid_i | input | 1 | Time base is valid |
| pcie_en_i | input | 1 | Strap: PCIe transport is present |
| pcie_link_i | input | 1 | PCIe link is up |
| pcie_sync_i | input | 1 | PCIe DMA/PPS synchronisation is established |
| eth_en_i | input | 1 | Strap: Ethernet transport is present |
| eth_link_i | input | 1 | Ethernet link is up |
| pps_stb_i | input | 1 | Pulse-per-second strobe |
| rf_stb_i | input | N_RF | Radio activity strobes |
| eth_rx_stb_i | input | 1 | Ethernet receive activity strobe |
| eth_tx_stb_i | input | 1 | Ethernet transmit activity strobe |
| led_o | output | 1 | Pulse-width-modulated LED drive |

## Verification
Some properties are checked by assertions on every cycle:
- A dark brightness always leaves the LED off in the next cycle.
- An active accent always lifts the brightness to the accent level.
- Any strobe arms the accent one cycle later.
- The breathing level never climbs above its peak.

The remaining behaviour is shown only by the bench scenarios, which measure lit cycles over 256-cycle windows at the pin:
- which base pattern each combination of readiness inputs selects;
- the placement of the heartbeat flashes;
- the full height of the breathing ramp;
- the length of an accent and its extension by a second strobe;
- the restart after reset.

// File: rtl/led_status_pkg.sv
package led_status_pkg;
  typedef logic [7:0] lvl_t;

  localparam lvl_t LVL_FULL = 8'hFF;

  function automatic lvl_t lvl_max(input lvl_t a, input lvl_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/led_base_pattern.sv
module led_base_pattern
  import led_status_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned     HB_FLASH_MS  = 80,
  parameter int unsigned     HB_GAP_MS    = 160,
  parameter int unsigned     HB_PERIOD_MS = 1000,
  parameter int unsigned     BREATH_MS    = 2000,
  parameter int unsigned     BREATH_PEAK  = 48,
  parameter int unsigned     HB_LEVEL     = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  output lvl_t level_o,
  output lvl_t breath_lvl_o
);
  localparam longint unsigned HB_CYC    = (CLK_HZ * HB_PERIOD_MS) / 1000;
  localparam longint unsigned FLASH_CYC = (CLK_HZ * HB_FLASH_MS) / 1000;
  localparam longint unsigned GAP_CYC   = (CLK_HZ * HB_GAP_MS) / 1000;
  localparam longint unsigned STEP_RAW  = (CLK_HZ * BREATH_MS) / (2000 * longint'(BREATH_PEAK));
  localparam longint unsigned STEP_CYC  = (STEP_RAW == 0) ? 1 : STEP_RAW;
  localparam int HB_W = (HB_CYC > 1) ? $clog2(HB_CYC) : 1;
  localparam int ST_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [HB_W-1:0] hb_q, hb_d;
  logic [ST_W-1:0] st_q, st_d;
  lvl_t            br_q, br_d;
  lvl_t            lvl_q, lvl_d;
  logic            up_q, up_d;
  logic            hb_wrap, st_wrap, flash;

  always_comb begin
    hb_wrap = (hb_q == HB_W'(HB_CYC - 1));
    hb_d    = hb_wrap ? '0 : hb_q + 1'b1;
    flash   = (hb_q < HB_W'(FLASH_CYC)) ||
              ((hb_q >= HB_W'(GAP_CYC)) && (hb_q < HB_W'(GAP_CYC + FLASH_CYC)));

    st_wrap = (st_q == ST_W'(STEP_CYC - 1));
    st_d    = st_wrap ? '0 : st_q + 1'b1;

    br_d = br_q;
    up_d = up_q;
    if (st_wrap) begin
      if (up_q) begin
        if (br_q >= lvl_t'(BREATH_PEAK)) begin
          up_d = 1'b0;
          br_d = br_q - 1'b1;
        end else begin
          br_d = br_q + 1'b1;
        end
      end else begin
        if (br_q == '0) begin
          up_d = 1'b1;
          br_d = br_q + 1'b1;
        end else begin
          br_d = br_q - 1'b1;
        end
      end
    end

    lvl_d = ready_i ? br_q : (flash ? lvl_t'(HB_LEVEL) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q  <= '0;
      st_q  <= '0;
      br_q  <= '0;
      up_q  <= 1'b1;
      lvl_q <= '0;
    end else begin
      hb_q  <= hb_d;
      st_q  <= st_d;
      br_q  <= br_d;
      up_q  <= up_d;
      lvl_q <= lvl_d;
    end
  end

  assign level_o      = lvl_q;
  assign breath_lvl_o = br_q;
endmodule

// File: rtl/led_accent.sv
module led_accent #(
  parameter longint unsigned HOLD_CYC = 5_000_000,
  parameter int unsigned     N_SRC    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] stb_i,
  output logic             act_o
);
  localparam int AC_W = $clog2(HOLD_CYC + 1);

  logic [AC_W-1:0] cnt_q, cnt_d;
  logic            hit;

  always_comb begin
    hit = |stb_i;
    if (hit)
      cnt_d = AC_W'(HOLD_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act_o = (cnt_q != '0);
endmodule

// File: rtl/led_pwm.sv
module led_pwm
  import led_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t bright_i,
  output logic led_o
);
  lvl_t cnt_q, cnt_d;
  logic led_q, led_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    led_d = (cnt_q < bright_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      led_q <= led_d;
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/led_status_layer.sv
module led_status_layer
  import led_status_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned     HB_FLASH_MS  = 80,
  parameter int unsigned     HB_GAP_MS    = 160,
  parameter int unsigned     HB_PERIOD_MS = 1000,
  parameter int unsigned     BREATH_MS    = 2000,
  parameter int unsigned     BREATH_PEAK  = 48,
  parameter int unsigned     HB_LEVEL     = 255,
  parameter int unsigned     ACCENT_MS    = 50,
  parameter int unsigned     ACCENT_LEVEL = 255,
  parameter int unsigned     N_RF         = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            time_valid_i,
  input  logic            pcie_en_i,
  input  logic            pcie_link_i,
  input  logic            pcie_sync_i,
  input  logic            eth_en_i,
  input  logic            eth_link_i,
  input  logic            pps_stb_i,
  input  logic [N_RF-1:0] rf_stb_i,
  input  logic            eth_rx_stb_i,
  input  logic            eth_tx_stb_i,
  output logic            led_o
);
  localparam longint unsigned ACC_CYC = (CLK_HZ * ACCENT_MS) / 1000;
  localparam int unsigned     N_SRC   = N_RF + 3;

  logic             pcie_ok, eth_ok, ready;
  logic [N_SRC-1:0] acc_src;
  logic             accent_act;
  lvl_t             base_lvl, breath_lvl, accent_lvl, bright;

  always_comb begin
    pcie_ok    = !pcie_en_i || (pcie_link_i && pcie_sync_i);
    eth_ok     = !eth_en_i || eth_link_i;
    ready      = time_valid_i && pcie_ok && eth_ok;
    acc_src    = {eth_tx_stb_i, eth_rx_stb_i, rf_stb_i, pps_stb_i};
    accent_lvl = accent_act ? lvl_t'(ACCENT_LEVEL) : '0;
    bright     = lvl_max(base_lvl, accent_lvl);
  end

  led_base_pattern #(
    .CLK_HZ      (CLK_HZ),
    .HB_FLASH_MS (HB_FLASH_MS),
    .HB_GAP_MS   (HB_GAP_MS),
    .HB_PERIOD_MS(HB_PERIOD_MS),
    .BREATH_MS   (BREATH_MS),
    .BREATH_PEAK (BREATH_PEAK),
    .HB_LEVEL    (HB_LEVEL)
  ) u_base (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_i     (ready),
    .level_o     (base_lvl),
    .breath_lvl_o(breath_lvl)
  );

  led_accent #(
    .HOLD_CYC(ACC_CYC),
    .N_SRC   (N_SRC)
  ) u_accent (
    .clk  (clk),
    .rst_n(rst_n),
    .stb_i(acc_src),
    .act_o(accent_act)
  );

  led_pwm u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .bright_i(bright),
    .led_o   (led_o)
  );
endmodule

// File: rtl/led_status_layer_chk.sv
module led_status_layer_chk
  import led_status_pkg::*;
#(
  parameter int unsigned BREATH_PEAK  = 48,
  parameter int unsigned ACCENT_LEVEL = 255
) (
  input logic clk,
  input logic rst_n,
  input logic any_stb,
  input logic accent_act,
  input lvl_t bright,
  input lvl_t breath_lvl,
  input logic led
);
  // R9: zero brightness leaves the pin dark on the following cycle
  a_r9_dark_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bright == '0) |=> !led);

  // R6: an active accent dominates the merged brightness
  a_r6_accent_floor: assert property (@(posedge clk) disable iff (!rst_n)
    accent_act |-> (bright >= lvl_t'(ACCENT_LEVEL)));

  // R4: the ramp stays at or below its peak
  a_r4_breath_cap: assert property (@(posedge clk) disable iff (!rst_n)
    breath_lvl <= lvl_t'(BREATH_PEAK));

  // R8: every strobe (re)arms the accent
  a_r8_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> accent_act);
endmodule

bind led_status_layer led_status_layer_chk #(
  .BREATH_PEAK (BREATH_PEAK),
  .ACCENT_LEVEL(ACCENT_LEVEL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .any_stb   (|acc_src),
  .accent_act(accent_act),
  .bright    (bright),
  .breath_lvl(breath_lvl),
  .led       (led_o)
);

// File: tb/led_status_layer_test.sv
module led_status_layer_test;
  localparam int CLK    = 10_000;
  localparam int PEAK   = 48;
  localparam int WIN    = 256;
  localparam int LIMIT  = 195_000;

  // mode vectors: {tv, pcie_en, pcie_link, pcie_sync, eth_en, eth_link, expect_heartbeat}
  localparam logic [6:0] MODE_TAB [0:8] = '{
    7'b0000001, 7'b1000000, 7'b1110001, 7'b1111000, 7'b1101001,
    7'b1000101, 7'b1000110, 7'b0111111, 7'b1001110
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tv, pe, pl, ps, ee, el;
  logic       pps, erx, etx;
  logic [1:0] rf;
  logic       led;
  int         tests = 0;
  int         fails = 0;
  int         cyc   = 0;
  bit         done  = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  led_status_layer #(.CLK_HZ(CLK), .N_RF(2)) uut (
    .clk(clk), .rst_n(rst_n), .time_valid_i(tv), .pcie_en_i(pe),
    .pcie_link_i(pl), .pcie_sync_i(ps), .eth_en_i(ee), .eth_link_i(el),
    .pps_stb_i(pps), .rf_stb_i(rf), .eth_rx_stb_i(erx), .eth_tx_stb_i(etx),
    .led_o(led)
  );

  function automatic string mode_tag(input int i);
    case (i)
      0, 7:    return "R1";
      2, 3, 4: return "R2";
      5, 6:    return "R3";
      8:       return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int lo, input int hi);
    tests++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic window(output int n);
    n = 0;
    repeat (WIN) begin
      @(negedge clk);
      n += int'(led);
    end
  endtask

  task automatic scan(input int nwin, output int mx, output int mn);
    int w;
    mx = 0;
    mn = WIN;
    for (int k = 0; k < nwin; k++) begin
      window(w);
      if (w > mx) mx = w;
      if (w < mn) mn = w;
    end
  endtask

  task automatic set_mode(input logic [6:0] v);
    {tv, pe, pl, ps, ee, el} = v[6:1];
  endtask

  task automatic pulse(input int src);
    case (src)
      0: pps = 1'b1;
      1: rf[0] = 1'b1;
      2: rf[1] = 1'b1;
      3: erx = 1'b1;
      default: etx = 1'b1;
    endcase
    @(negedge clk);
    pps = 1'b0; rf = '0; erx = 1'b0; etx = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= LIMIT);
    tests++;
    fails++;
    $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, LIMIT);
    finish_run();
  end

  initial begin
    int n, mx, mn;
    rst_n = 1'b0;
    {tv, pe, pl, ps, ee, el} = '0;
    pps = 1'b0; rf = '0; erx = 1'b0; etx = 1'b0;
    wait_cyc(5);
    chk("R10 led off in reset", int'(led), 0, 0);
    rst_n = 1'b1;

    // R5 / R10 heartbeat flash placement from the reset release
    wait_cyc(100);
    window(n); chk("R5 first flash", n, 255, 255);
    wait_cyc(644);
    window(n); chk("R5 gap between flashes", n, 0, 0);
    wait_cyc(444);
    window(n); chk("R5 second flash", n, 255, 255);
    wait_cyc(1044);
    window(n); chk("R5 pause", n, 0, 0);
    wait_cyc(6844);
    window(n); chk("R5 next period flash", n, 255, 255);

    // Readiness table: heartbeat reaches full windows, breathing stays below peak
    for (int i = 0; i < 9; i++) begin
      set_mode(MODE_TAB[i]);
      wait_cyc(300);
      scan(40, mx, mn);
      if (MODE_TAB[i][0]) chk({mode_tag(i), " heartbeat expected"}, mx, 250, 255);
      else                chk({mode_tag(i), " breathing expected"}, mx, 0, PEAK);
    end

    // R4 full ramp in the ready state
    set_mode(7'b1000000);
    wait_cyc(300);
    scan(80, mx, mn);
    chk("R4 ramp peak", mx, PEAK - 2, PEAK);
    chk("R4 ramp floor", mn, 0, 2);

    // R6 each strobe source gives a full accent, then expires (R9 duty)
    for (int s = 0; s < 5; s++) begin
      pulse(s);
      wait_cyc(49);
      window(n); chk("R6 accent full", n, 255, 255);
      wait_cyc(350);
      window(n); chk("R6 accent expired", n, 0, PEAK);
    end

    // R8 retrigger extends the accent
    pulse(0);
    wait_cyc(399);
    pulse(1);
    wait_cyc(219);
    window(n); chk("R8 extended accent", n, 255, 255);
    wait_cyc(300);
    window(n); chk("R8 accent ends after extension", n, 0, PEAK);

    // R10 reset mid-run restarts the heartbeat phase
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    chk("R10 led off during second reset", int'(led), 0, 0);
    set_mode(7'b0000001);
    rst_n = 1'b1;
    wait_cyc(100);
    window(n); chk("R10 flash restarts after reset", n, 255, 255);

    finish_run();
  end
endmodule